// File: doc/BRIEF.md
# Stochastic Conversion Chain with Programmable Bit-Flip Injection

This block turns binary operands into stochastic pulse streams, corrupts those streams with random bit flips at a rate set by a binary word, and turns the corrupted streams back into binary counts. It is used to measure how a stochastic encoding degrades as noise rises. Each channel carries one operand, so a ratio-encoded value needs two channels: one for the numerator and one for the denominator. Every channel has its own flip source.

Each operand drives a level-to-pulse converter. In every cycle, that converter emits a 1 when a free-running pseudo-random word is at or below the operand. A second converter of the same kind, driven by the shared flip-rate word, produces a flip stream that is XORed into the data stream. All converters start from distinct non-zero seeds derived from one seed input. A shared window sequencer opens an evaluation window of 2^N cycles, where N is chosen at start. During the window, one accumulator per channel counts the ones on the noisy stream. At the end of the window the counts are held and a done pulse is raised for one cycle.

Top module: `sc_noise_chain`

## Requirements
- R1: While reset is asserted, every count is zero, done is low, and both the clean and the noisy streams are 0.
- R2: A clean stream bit is 1 exactly when the channel's random word is less than or equal to the operand. The random words are never zero, so an operand of 0 gives a stream that is always 0. An operand of all ones gives a stream that is always 1.
- R3: The random source for a DW-bit operand is a maximal-length shift register with period 2^DW-1. Over any window of 2^DW cycles, the count of clean ones is either the operand value or the operand value plus one.
- R4: A noisy bit equals the clean bit XOR a flip bit. The flip bit is 1 when the bit-reversed word of the channel's noise source is at most the rate. A rate of 0 leaves the noisy stream identical to the clean stream.
- R5: A rate of all ones inverts every clean bit, so the noisy stream is the complement of the clean stream in every cycle.
- R6: Over a 2^DW-cycle window, the number of flipped bits on each channel is either the rate or the rate plus one. The flip patterns of different channels are not identical.
- R7: The window length is 2^N cycles. N is the window-size input sampled at start, clamped to the range 1 to CNT_W. An input of 0 gives 2 cycles.
- R8: Start zeroes every count. Each channel then adds up its noisy stream over exactly the window cycles, so each count equals the number of ones that appeared on that channel's noisy output.
- R9: Done goes high for exactly one cycle, in the cycle after the last counted sample. The counts then hold until the next start or clear.
- R10: Clear takes priority over start. It zeroes the counts, ends any window without a done pulse, and reloads every random source from the seed input. A start during a running window abandons that window without a done pulse and begins a new one.
- R11: After a clear, the clean and noisy streams depend only on the seed. Two clears with the same seed produce the same stream sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear and seed reload |
| start | input | 1 | Opens a new evaluation window |
| win_bits | input | WB_W | Window exponent N, sampled at start |
| seed | input | DW | Seed applied by clear |
| value | input | NCH*DW | Operand per channel, channel 0 in the low bits |
| rate | input | DW | Flip-rate word shared by all channels |
| clean | output | NCH | Stochastic stream per channel, before flips |
| noisy | output | NCH | Stochastic stream per channel, after flips |
| count | output | NCH*(CNT_W+1) | Windowed ones count per channel |
| done | output | 1 | One-cycle pulse when a window ends |

## Verification
Three pairs of control events can meet on one clock edge. Start and clear can be raised together. A start can arrive in the last cycle of a window, exactly where done would otherwise be produced. A second start can arrive in the middle of a running window. The bench drives each of these collisions on purpose. Its behavioural window model decides the result from the priority rules: clear wins over start, and start abandons the old window without a done pulse. The bench compares that model's counts and done against the ports on every clock, and it also checks that the number of completed windows rises by exactly one.

// File: rtl/sc_pkg.sv
package sc_pkg;

   // Feedback mask of a maximal-length shift register, bit i = tap i+1.
   function automatic logic [31:0] lfsr_taps(input int w);
      case (w)
         8:       return 32'h0000_00B8;
         10:      return 32'h0000_0240;
         12:      return 32'h0000_0829;
         14:      return 32'h0000_2015;
         16:      return 32'h0000_D008;
         default: return 32'h0000_0000;
      endcase
   endfunction

   // Per-source seed offset; odd multiplier keeps offsets distinct.
   function automatic logic [31:0] seed_offset(input int idx);
      return 32'h0000_06B3 * 32'(idx + 1);
   endfunction

endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
   parameter int               W       = 12,
   parameter logic [W-1:0]     TAPS    = '0,
   parameter logic [W-1:0]     RST_VAL = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] q
);

   logic fb;
   assign fb = ^(q & TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= load_val;
      else           q <= {q[W-2:0], fb};
   end

endmodule

// File: rtl/sc_b2p.sv
module sc_b2p
   import sc_pkg::*;
#(
   parameter int W          = 12,
   parameter int IDX        = 0,
   parameter bit REVERSE    = 1'b0,
   parameter int RESET_SEED = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic [W-1:0] level,
   output logic         pulse
);

   localparam logic [W-1:0] TAPS = W'(lfsr_taps(W));
   localparam logic [W-1:0] OFFS = W'(seed_offset(IDX));
   localparam logic [W-1:0] RMIX = W'(RESET_SEED) ^ OFFS;
   localparam logic [W-1:0] RVAL = (RMIX == '0) ? W'(1) : RMIX;

   logic [W-1:0] mixed, load_val, q, word;

   assign mixed    = seed ^ OFFS;
   assign load_val = (mixed == '0) ? W'(1) : mixed;

   sc_lfsr #(.W(W), .TAPS(TAPS), .RST_VAL(RVAL)) u_lfsr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .q        (q)
   );

   generate
      if (REVERSE) begin : g_rev
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign word[i] = q[W-1-i];
         end
      end else begin : g_fwd
         assign word = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pulse <= 1'b0;
      else if (load) pulse <= 1'b0;
      else           pulse <= (word <= level);
   end

endmodule

// File: rtl/sc_window_ctl.sv
module sc_window_ctl #(
   parameter int CNT_W = 24,
   parameter int WB_W  = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            start,
   input  logic [WB_W-1:0] win_bits,
   output logic            acc_zero,
   output logic            acc_en,
   output logic            done
);

   localparam int              CW   = CNT_W + 1;
   localparam logic [WB_W-1:0] MAXN = WB_W'(CNT_W);

   logic            busy;
   logic [CW-1:0]   left;
   logic [WB_W-1:0] n_eff;

   always_comb begin
      if (win_bits == '0)       n_eff = WB_W'(1);
      else if (win_bits > MAXN) n_eff = MAXN;
      else                      n_eff = win_bits;
   end

   assign acc_zero = start | clear;
   assign acc_en   = busy & ~start & ~clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         left <= '0;
         done <= 1'b0;
      end else if (clear) begin
         busy <= 1'b0;
         left <= '0;
         done <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         left <= CW'(1) << n_eff;
         done <= 1'b0;
      end else if (busy) begin
         left <= left - CW'(1);
         if (left == CW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            done <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end

endmodule

// File: rtl/sc_p2b.sv
module sc_p2b #(
   parameter int CNT_W = 24
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           zero,
   input  logic           en,
   input  logic           bit_in,
   output logic [CNT_W:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (zero) count <= '0;
      else if (en)   count <= count + (CNT_W+1)'(bit_in);
   end

endmodule

// File: rtl/sc_noise_chain.sv
module sc_noise_chain
   import sc_pkg::*;
#(
   parameter int NCH        = 2,
   parameter int DW         = 12,
   parameter int CNT_W      = 24,
   parameter int WB_W       = 5,
   parameter int RESET_SEED = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     start,
   input  logic [WB_W-1:0]          win_bits,
   input  logic [DW-1:0]            seed,
   input  logic [NCH*DW-1:0]        value,
   input  logic [DW-1:0]            rate,
   output logic [NCH-1:0]           clean,
   output logic [NCH-1:0]           noisy,
   output logic [NCH*(CNT_W+1)-1:0] count,
   output logic                     done
);

   localparam int CW = CNT_W + 1;

   generate
      if (lfsr_taps(DW) == 32'd0) begin : g_bad_dw
         $error("sc_noise_chain: DW must be 8, 10, 12, 14 or 16");
      end
      if (CNT_W < DW || CNT_W > 30) begin : g_bad_cnt
         $error("sc_noise_chain: CNT_W must lie between DW and 30");
      end
      if ((1 << WB_W) <= CNT_W) begin : g_bad_wb
         $error("sc_noise_chain: WB_W too narrow for CNT_W");
      end
      if (NCH < 1) begin : g_bad_nch
         $error("sc_noise_chain: NCH must be at least 1");
      end
   endgenerate

   logic acc_zero, acc_en;
   logic [NCH-1:0] flip;

   sc_window_ctl #(.CNT_W(CNT_W), .WB_W(WB_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .start    (start),
      .win_bits (win_bits),
      .acc_zero (acc_zero),
      .acc_en   (acc_en),
      .done     (done)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         sc_b2p #(.W(DW), .IDX(2*c), .REVERSE(1'b0),
                  .RESET_SEED(RESET_SEED)) u_data (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (clear),
            .seed  (seed),
            .level (value[c*DW +: DW]),
            .pulse (clean[c])
         );

         sc_b2p #(.W(DW), .IDX(2*c+1), .REVERSE(1'b1),
                  .RESET_SEED(RESET_SEED)) u_noise (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (clear),
            .seed  (seed),
            .level (rate),
            .pulse (flip[c])
         );

         assign noisy[c] = clean[c] ^ flip[c];

         sc_p2b #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .zero   (acc_zero),
            .en     (acc_en),
            .bit_in (noisy[c]),
            .count  (count[c*CW +: CW])
         );
      end
   endgenerate

endmodule

// File: rtl/sc_noise_chain_chk.sv
module sc_noise_chain_chk #(
   parameter int NCH   = 2,
   parameter int DW    = 12,
   parameter int CNT_W = 24,
   parameter int WB_W  = 5
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     clear,
   input logic                     start,
   input logic [WB_W-1:0]          win_bits,
   input logic [NCH*DW-1:0]        value,
   input logic [DW-1:0]            rate,
   input logic [NCH-1:0]           clean,
   input logic [NCH-1:0]           noisy,
   input logic [NCH*(CNT_W+1)-1:0] count,
   input logic                     done
);

   localparam int CW = CNT_W + 1;

   // R9: done lasts a single cycle
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: clear leaves zero counts and no done
   assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clear) |-> (!done && count == '0));

   // R4: zero rate gives no flips
   assert_rate_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rate) == '0) |-> (noisy == clean));

   // R5: full rate inverts every bit
   assert_full_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(clear) && (&$past(rate))) |-> (noisy == ~clean));

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_chk
         // R2: full-scale operand gives a constant 1
         assert_full_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(clear) && (&$past(value[c*DW +: DW])))
            |-> clean[c]);

         // R2: zero operand gives a constant 0
         assert_zero_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(value[c*DW +: DW]) == '0) |-> !clean[c]);

         // R8: a count never exceeds the longest window
         assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            count[c*CW +: CW] <= (CW'(1) << CNT_W));
      end
   endgenerate

   // R7: inputs to the sequencer are known once out of reset
   assert_win_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !$isunknown(win_bits));

endmodule

bind sc_noise_chain sc_noise_chain_chk #(
   .NCH(NCH), .DW(DW), .CNT_W(CNT_W), .WB_W(WB_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clear    (clear),
   .start    (start),
   .win_bits (win_bits),
   .value    (value),
   .rate     (rate),
   .clean    (clean),
   .noisy    (noisy),
   .count    (count),
   .done     (done)
);

// File: tb/tb_sc_noise_chain.sv
module tb_sc_noise_chain;
   localparam int NCH = 2, DW = 12, CNT_W = 24, WB_W = 5, CW = CNT_W + 1;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic                 rst_n = 1'b0, clear = 1'b0, start = 1'b0;
   logic [WB_W-1:0]      win_bits = '0;
   logic [DW-1:0]        seed = '0, rate = '0;
   logic [NCH*DW-1:0]    value = '0;
   logic [NCH-1:0]       clean, noisy;
   logic [NCH*CW-1:0]    count;
   logic                 done;

   sc_noise_chain #(.NCH(NCH), .DW(DW), .CNT_W(CNT_W), .WB_W(WB_W)) dut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .start(start),
      .win_bits(win_bits), .seed(seed), .value(value), .rate(rate),
      .clean(clean), .noisy(noisy), .count(count), .done(done));

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // behavioural window model
   bit     m_busy = 0, m_done = 0;
   longint m_left = 0, m_len = 0, r_len = 0, m_dif = 0, r_dif = 0;
   longint m_cnt[NCH], m_cl[NCH], m_fl[NCH], r_cl[NCH], r_fl[NCH];
   int     runs = 0;
   int     mode = 0;  // 1: rate 0 per-cycle, 2: full rate per-cycle

   initial for (int c = 0; c < NCH; c++) begin
      m_cnt[c] = 0; m_cl[c] = 0; m_fl[c] = 0; r_cl[c] = 0; r_fl[c] = 0;
   end

   function automatic int eff_n(input int w);
      if (w == 0) return 1;
      if (w > CNT_W) return CNT_W;
      return w;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         for (int c = 0; c < NCH; c++)
            chk(count[c*CW +: CW] == CW'(m_cnt[c]), "R8", "count",
                longint'(count[c*CW +: CW]), m_cnt[c]);
         chk(done == m_done, "R9", "done", longint'(done), longint'(m_done));
         if (mode == 1)
            chk(noisy == clean, "R4", "noisy vs clean at rate 0",
                longint'(noisy), longint'(clean));
         if (mode == 2) begin
            chk(noisy == ~clean, "R5", "noisy vs clean at full rate",
                longint'(noisy), longint'(~clean));
            chk(clean == 2'b10, "R2", "clean at operands 0 and full",
                longint'(clean), 2);
         end
         // prediction for the coming edge
         if (clear) begin
            m_busy = 0; m_done = 0;
            for (int c = 0; c < NCH; c++) m_cnt[c] = 0;
         end else if (start) begin
            m_busy = 1; m_done = 0; m_len = 0; m_dif = 0;
            m_left = longint'(1) << eff_n(int'(win_bits));
            for (int c = 0; c < NCH; c++) begin
               m_cnt[c] = 0; m_cl[c] = 0; m_fl[c] = 0;
            end
         end else if (m_busy) begin
            for (int c = 0; c < NCH; c++) begin
               m_cnt[c] += longint'(noisy[c]);
               m_cl[c]  += longint'(clean[c]);
               m_fl[c]  += longint'(noisy[c] ^ clean[c]);
            end
            m_dif += longint'((noisy[0] ^ clean[0]) ^ (noisy[1] ^ clean[1]));
            m_len++;
            m_left--;
            if (m_left == 0) begin
               m_busy = 0; m_done = 1; runs++;
               r_len = m_len; r_dif = m_dif;
               for (int c = 0; c < NCH; c++) begin
                  r_cl[c] = m_cl[c]; r_fl[c] = m_fl[c];
               end
            end else m_done = 0;
         end else m_done = 0;
      end
   end

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #2; end
   endtask

   task automatic run_window(input int wb);
      int r0;
      r0 = runs;
      win_bits = WB_W'(wb);
      start = 1'b1; tick(1); start = 1'b0;
      while (runs == r0) tick(1);
      tick(1);
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
   end

   logic [2*NCH-1:0] rec_a[40], rec_b[40];

   initial begin
      int r0;
      // R1: reset state
      @(negedge clk);
      chk(count == '0, "R1", "count in reset", longint'(count), 0);
      chk(done == 1'b0, "R1", "done in reset", longint'(done), 0);
      chk(clean == '0 && noisy == '0, "R1", "streams in reset",
          longint'({noisy, clean}), 0);
      tick(1);
      rst_n = 1'b1;
      seed = 12'h3A7; clear = 1'b1; tick(1); clear = 1'b0;

      // R3, R4: rate 0, full-period window
      value = {12'd3000, 12'd1000}; rate = '0; tick(2);
      mode = 1;
      run_window(12);
      mode = 0;
      chk(r_cl[0] >= 1000 && r_cl[0] <= 1001, "R3", "clean ones ch0", r_cl[0], 1000);
      chk(r_cl[1] >= 3000 && r_cl[1] <= 3001, "R3", "clean ones ch1", r_cl[1], 3000);
      chk(count[CW-1:0] >= 1000 && count[CW-1:0] <= 1001, "R8",
          "held count ch0 at rate 0", longint'(count[CW-1:0]), 1000);
      chk(r_len == 4096, "R7", "window length 2^12", r_len, 4096);

      // R6: flip fraction tracks the rate
      rate = 12'd1229; tick(2);
      run_window(12);
      for (int c = 0; c < NCH; c++)
         chk(r_fl[c] >= 1229 && r_fl[c] <= 1230, "R6", "flip count", r_fl[c], 1229);
      chk(r_dif > 0, "R6", "channels flip independently", r_dif, 1);
      chk(r_cl[1] >= 3000 && r_cl[1] <= 3001, "R3", "clean ones under noise",
          r_cl[1], 3000);

      // R2, R5: extreme operands and full rate
      value = {12'hFFF, 12'h000}; rate = 12'hFFF; tick(2);
      mode = 2;
      run_window(12);
      mode = 0;
      chk(r_cl[0] == 0, "R2", "ones with operand 0", r_cl[0], 0);
      chk(r_cl[1] == 4096, "R2", "ones with full operand", r_cl[1], 4096);
      chk(count[CW-1:0] == 4096, "R5", "inverted count ch0",
          longint'(count[CW-1:0]), 4096);
      chk(count[2*CW-1:CW] == 0, "R5", "inverted count ch1",
          longint'(count[2*CW-1:CW]), 0);

      // R7: window clamp and short windows
      value = {12'd2048, 12'd777}; rate = 12'd2000; tick(2);
      run_window(0);
      chk(r_len == 2, "R7", "window for exponent 0", r_len, 2);
      run_window(3);
      chk(r_len == 8, "R7", "window for exponent 3", r_len, 8);
      tick(5);
      chk(count[CW-1:0] == CW'(m_cnt[0]), "R9", "count held after done",
          longint'(count[CW-1:0]), m_cnt[0]);

      // R10: clear aborts a window
      r0 = runs;
      win_bits = WB_W'(6); start = 1'b1; tick(1); start = 1'b0;
      tick(10);
      clear = 1'b1; tick(1); clear = 1'b0;
      tick(100);
      chk(runs == r0, "R10", "windows finished after clear", runs - r0, 0);
      chk(count == '0, "R10", "counts after clear", longint'(count), 0);

      // R10: start and clear together, clear wins
      start = 1'b1; clear = 1'b1; tick(1); start = 1'b0; clear = 1'b0;
      tick(80);
      chk(runs == r0, "R10", "start with clear opened no window", runs - r0, 0);

      // R10: restart mid-window
      r0 = runs;
      win_bits = WB_W'(5); start = 1'b1; tick(1); start = 1'b0;
      tick(20);
      start = 1'b1; tick(1); start = 1'b0;
      while (runs == r0) tick(1);
      tick(40);
      chk(runs - r0 == 1, "R10", "done pulses after restart", runs - r0, 1);
      chk(r_len == 32, "R10", "restarted window length", r_len, 32);

      // R10: start in the last cycle of a window
      r0 = runs;
      win_bits = WB_W'(4); start = 1'b1; tick(1); start = 1'b0;
      while (!(m_busy && m_left == 1)) tick(1);
      start = 1'b1; tick(1); start = 1'b0;
      while (runs == r0) tick(1);
      tick(40);
      chk(runs - r0 == 1, "R10", "done pulses with start at end", runs - r0, 1);
      chk(r_len == 16, "R10", "window after late start", r_len, 16);

      // R11: same seed repeats the streams
      seed = 12'h5C1; clear = 1'b1; tick(1); clear = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); rec_a[i] = {noisy, clean};
      end
      tick(1);
      clear = 1'b1; tick(1); clear = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk); rec_b[i] = {noisy, clean};
      end
      begin
         int diff;
         diff = 0;
         for (int i = 0; i < 40; i++) if (rec_a[i] != rec_b[i]) diff++;
         chk(diff == 0, "R11", "stream mismatches after reseed", diff, 0);
      end
      tick(2);
      summary();
      $finish;
   end

endmodule